// File: doc/BRIEF.md
# IPv4 Header Checksum Insertion Engine

This block runs once per transmit frame that already sits complete in a byte-addressed frame buffer. After a start strobe it reads the EtherType and the first byte of the IP header. For an IPv4 frame it reads the whole IP header, forms the Internet checksum and writes the two checksum bytes back into the buffer. For an IPv6 frame it writes nothing, but it walks the fixed header and any chain of extension headers to make sure they fit inside the frame. Every other frame is left alone.

The block has a single buffer port. A read returns its byte on the cycle after the address is issued, and a write stores a byte at the clock edge. When the run ends, a one-cycle completion pulse is raised and a header-error flag gives the verdict. The flag holds its value until the next start. When the frame is not held whole in the buffer (the store-and-forward input is low), the engine does nothing and reports no error.

States: `ST_IDLE`, `ST_TYPE_HI`, `ST_TYPE_LO` (classify), `ST_VERSION` (header checks), `ST_SUM` (one header byte per cycle), `ST_FOLD`, `ST_WR_HI`, `ST_WR_LO`, `ST_V6_NH`, `ST_EXT_CHK`, `ST_EXT_NH`, `ST_EXT_LEN` and `ST_DONE`.

Transitions:
- `ST_IDLE`→`ST_TYPE_HI` on a start that is worth parsing.
- `ST_IDLE`→`ST_DONE` when store-and-forward is low or the frame is shorter than 14 bytes.
- `ST_TYPE_HI`→`ST_TYPE_LO`.
- `ST_TYPE_LO`→`ST_VERSION` for either IP type when the frame has at least 15 bytes. Otherwise `ST_TYPE_LO`→`ST_DONE`.
- `ST_VERSION`→`ST_SUM` for a good IPv4 header.
- `ST_VERSION`→`ST_V6_NH` for a good IPv6 header.
- `ST_VERSION`→`ST_DONE` on any error.
- `ST_SUM` loops until the last header byte has arrived, then `ST_SUM`→`ST_FOLD`→`ST_WR_HI`→`ST_WR_LO`→`ST_DONE`.
- `ST_V6_NH`→`ST_EXT_CHK`.
- `ST_EXT_CHK`→`ST_EXT_NH`→`ST_EXT_LEN`→`ST_EXT_CHK` for each extension header.
- `ST_EXT_CHK`→`ST_DONE` or `ST_EXT_LEN`→`ST_DONE` when the chain ends or an error is found.
- `ST_DONE`→`ST_IDLE`.

Top module: `iphdr_csum_ins`

## Requirements
- R1: When bytes 12..13 (big-endian) hold 0x0800 and the high nibble of byte 14 is 4, the engine writes the checksum into the frame. The header length in bytes is L = 4 × (low nibble of byte 14). The checksum is the ones'-complement of the ones'-complement sum of the big-endian 16-bit words in bytes 14..14+L-1, with bytes 24 and 25 counted as zero. The engine writes the high byte of the checksum to byte 24 and the low byte to byte 25, and writes no other byte.
- R2: When the type is 0x0800 and the version nibble is not 4, `hdr_err` is set and no byte is written.
- R3: When the type is 0x0800 and the low nibble of byte 14 is below 5, `hdr_err` is set and no byte is written.
- R4: When the type is 0x0800 and 14 + L exceeds `frame_len`, `hdr_err` is set and no byte is written. A header that ends exactly at the end of the frame is accepted.
- R5: When bytes 12..13 hold 0x86DD, no byte is written. If the version nibble of byte 14 is not 6, `hdr_err` is set.
- R6: An IPv6 frame shorter than 54 bytes (14 + a 40-byte fixed header) sets `hdr_err`.
- R7: IPv6 extension headers are followed as a chain.
  - The first next-header code is byte 20. Codes 0, 43, 44 and 60 mark an extension header; the first one starts at byte 54.
  - Each extension header holds its successor's code in its first byte. Its length is (second byte + 1) × 8.
  - `hdr_err` is set when `frame_len` ends before the header's first two bytes, or before the header's full length.
  - At most MAX_EXT (default 4) extension headers are checked. After that, or at any other code, the walk stops with no error.
- R8: Any other type, and any frame shorter than 14 bytes, leaves every byte unchanged with `hdr_err` clear. A frame typed 0x0800 or 0x86DD that is shorter than 15 bytes sets `hdr_err`.
- R9: While `store_fwd` is low at start, no byte is written, `hdr_err` is clear, and `done` follows on the next cycle.
- R10: Each start gives exactly one `done` pulse, one cycle wide. `hdr_err` is cleared at start and is valid from `done` until the next start.
- R11: Reads are issued only at addresses below the frame length. A read and a write never happen in the same cycle. Read data is taken one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins processing of the buffered frame |
| store_fwd | input | 1 | High when the whole frame is held in the buffer |
| frame_len | input | LEN_W | Frame length in bytes, sampled at start |
| mem_rd | output | 1 | Buffer read request |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | LEN_W | Buffer byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned one cycle after a read |
| done | output | 1 | One-cycle completion pulse |
| hdr_err | output | 1 | Header-error verdict, valid from done until the next start |

## Verification
The assertions rely on three things about the inputs:
- `start` arrives only while the engine is idle.
- `frame_len` describes the frame actually present in the buffer.
- `mem_rdata` carries the byte addressed on the previous cycle.

The bench keeps to this in three ways. It raises `start` only after the previous `done` has been seen. It loads each frame into its buffer model before the strobe. Its buffer model answers reads with exactly one cycle of latency.

// File: rtl/ipck_pkg.sv
package ipck_pkg;

    localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
    localparam logic [15:0] ETYPE_IPV6   = 16'h86DD;
    localparam int          ETYPE_OFF    = 12;
    localparam int          HDR_OFF      = 14;
    localparam int          CSUM_REL     = 10;
    localparam int          V6_FIXED     = 40;
    localparam int          V6_NH_REL    = 6;
    localparam int          V4_MIN_WORDS = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TYPE_HI,
        ST_TYPE_LO,
        ST_VERSION,
        ST_SUM,
        ST_FOLD,
        ST_WR_HI,
        ST_WR_LO,
        ST_V6_NH,
        ST_EXT_CHK,
        ST_EXT_NH,
        ST_EXT_LEN,
        ST_DONE
    } ipck_state_e;

    function automatic logic is_v6_ext(input logic [7:0] code);
        return (code == 8'd0) || (code == 8'd43) || (code == 8'd44) || (code == 8'd60);
    endfunction

endpackage

// File: rtl/ipck_acc.sv
module ipck_acc #(
    parameter int ACC_W = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add_en,
    input  logic        add_hi,
    input  logic [7:0]  data_in,
    output logic [15:0] csum_out
);
    localparam int TOP_W = ACC_W - 16;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend;
    logic [16:0]      fold1;
    logic [16:0]      fold2;

    assign addend = add_hi ? ACC_W'({data_in, 8'h00}) : ACC_W'(data_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= acc_q + addend;
        end
    end

    always_comb begin
        fold1    = {1'b0, acc_q[15:0]} + 17'(acc_q[ACC_W-1 -: TOP_W]);
        fold2    = {1'b0, fold1[15:0]} + 17'(fold1[16]);
        csum_out = ~fold2[15:0];
    end

    AST_ACC_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> !acc_q[ACC_W-1]); // R1

endmodule

// File: rtl/iphdr_csum_ins.sv
module iphdr_csum_ins
    import ipck_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int MAX_EXT = 4,
    parameter int ACC_W   = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             store_fwd,
    input  logic [LEN_W-1:0] frame_len,
    output logic             mem_rd,
    output logic             mem_we,
    output logic [LEN_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic             done,
    output logic             hdr_err
);
    localparam int OW    = LEN_W + 2;
    localparam int CNT_W = $clog2(MAX_EXT + 1);

    ipck_state_e      state, nxt;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       type_hi_q;
    logic             is_v4_q;
    logic [5:0]       hl_q;
    logic [5:0]       rel_q;
    logic [7:0]       nh_q;
    logic [OW-1:0]    off_q;
    logic [CNT_W-1:0] ext_cnt_q;
    logic [15:0]      csum_q;
    logic             err_q;

    logic             err_set;
    logic             acc_clr, acc_add, acc_hi;
    logic [7:0]       acc_byte;
    logic [15:0]      acc_csum;
    logic [15:0]      type_w;
    logic [OW-1:0]    len_w, v4_end, ext_len;

    assign type_w  = {type_hi_q, mem_rdata};
    assign len_w   = OW'(len_q);
    assign v4_end  = OW'(HDR_OFF) + OW'({mem_rdata[3:0], 2'b00});
    assign ext_len = OW'({mem_rdata, 3'b000}) + OW'(8);

    ipck_acc #(.ACC_W(ACC_W)) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add_en   (acc_add),
        .add_hi   (acc_hi),
        .data_in  (acc_byte),
        .csum_out (acc_csum)
    );

    // state register and datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            len_q     <= '0;
            type_hi_q <= '0;
            is_v4_q   <= 1'b0;
            hl_q      <= '0;
            rel_q     <= '0;
            nh_q      <= '0;
            off_q     <= '0;
            ext_cnt_q <= '0;
            csum_q    <= '0;
            err_q     <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: if (start) begin
                    len_q <= frame_len;
                    err_q <= 1'b0;
                end
                ST_TYPE_HI: type_hi_q <= mem_rdata;
                ST_TYPE_LO: is_v4_q   <= (type_w == ETYPE_IPV4);
                ST_VERSION: begin
                    hl_q  <= {mem_rdata[3:0], 2'b00};
                    rel_q <= 6'd1;
                end
                ST_SUM:  rel_q  <= rel_q + 6'd1;
                ST_FOLD: csum_q <= acc_csum;
                ST_V6_NH: begin
                    nh_q      <= mem_rdata;
                    off_q     <= OW'(HDR_OFF + V6_FIXED);
                    ext_cnt_q <= '0;
                end
                ST_EXT_NH: nh_q <= mem_rdata;
                ST_EXT_LEN: begin
                    off_q     <= off_q + ext_len;
                    ext_cnt_q <= ext_cnt_q + 1'b1;
                end
                default: ;
            endcase
            if (err_set) err_q <= 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        err_set   = 1'b0;
        acc_clr   = 1'b0;
        acc_add   = 1'b0;
        acc_hi    = 1'b0;
        acc_byte  = mem_rdata;
        unique case (state)
            ST_IDLE: if (start) begin
                acc_clr = 1'b1;
                if (!store_fwd || frame_len < LEN_W'(HDR_OFF)) begin
                    nxt = ST_DONE;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = LEN_W'(ETYPE_OFF);
                    nxt      = ST_TYPE_HI;
                end
            end
            ST_TYPE_HI: begin
                mem_rd   = 1'b1;
                mem_addr = LEN_W'(ETYPE_OFF + 1);
                nxt      = ST_TYPE_LO;
            end
            ST_TYPE_LO: begin
                if (type_w == ETYPE_IPV4 || type_w == ETYPE_IPV6) begin
                    if (len_q < LEN_W'(HDR_OFF + 1)) begin
                        err_set = 1'b1;
                        nxt     = ST_DONE;
                    end else begin
                        mem_rd   = 1'b1;
                        mem_addr = LEN_W'(HDR_OFF);
                        nxt      = ST_VERSION;
                    end
                end else begin
                    nxt = ST_DONE;
                end
            end
            ST_VERSION: begin
                if (is_v4_q) begin
                    if (mem_rdata[7:4] != 4'd4 || mem_rdata[3:0] < 4'(V4_MIN_WORDS)
                        || v4_end > len_w) begin
                        err_set = 1'b1;
                        nxt     = ST_DONE;
                    end else begin
                        acc_add  = 1'b1;
                        acc_hi   = 1'b1;
                        mem_rd   = 1'b1;
                        mem_addr = LEN_W'(HDR_OFF + 1);
                        nxt      = ST_SUM;
                    end
                end else begin
                    if (mem_rdata[7:4] != 4'd6 || len_q < LEN_W'(HDR_OFF + V6_FIXED)) begin
                        err_set = 1'b1;
                        nxt     = ST_DONE;
                    end else begin
                        mem_rd   = 1'b1;
                        mem_addr = LEN_W'(HDR_OFF + V6_NH_REL);
                        nxt      = ST_V6_NH;
                    end
                end
            end
            ST_SUM: begin
                acc_add  = 1'b1;
                acc_hi   = !rel_q[0];
                acc_byte = (rel_q == 6'(CSUM_REL) || rel_q == 6'(CSUM_REL + 1)) ? 8'h00 : mem_rdata;
                if ({1'b0, rel_q} + 7'd1 < {1'b0, hl_q}) begin
                    mem_rd   = 1'b1;
                    mem_addr = LEN_W'(HDR_OFF) + LEN_W'(rel_q) + LEN_W'(1);
                end else begin
                    nxt = ST_FOLD;
                end
            end
            ST_FOLD: nxt = ST_WR_HI;
            ST_WR_HI: begin
                mem_we    = 1'b1;
                mem_addr  = LEN_W'(HDR_OFF + CSUM_REL);
                mem_wdata = csum_q[15:8];
                nxt       = ST_WR_LO;
            end
            ST_WR_LO: begin
                mem_we    = 1'b1;
                mem_addr  = LEN_W'(HDR_OFF + CSUM_REL + 1);
                mem_wdata = csum_q[7:0];
                nxt       = ST_DONE;
            end
            ST_V6_NH: nxt = ST_EXT_CHK;
            ST_EXT_CHK: begin
                if (is_v6_ext(nh_q) && ext_cnt_q < CNT_W'(MAX_EXT)) begin
                    if (off_q + OW'(2) > len_w) begin
                        err_set = 1'b1;
                        nxt     = ST_DONE;
                    end else begin
                        mem_rd   = 1'b1;
                        mem_addr = off_q[LEN_W-1:0];
                        nxt      = ST_EXT_NH;
                    end
                end else begin
                    nxt = ST_DONE;
                end
            end
            ST_EXT_NH: begin
                mem_rd   = 1'b1;
                mem_addr = off_q[LEN_W-1:0] + LEN_W'(1);
                nxt      = ST_EXT_LEN;
            end
            ST_EXT_LEN: begin
                if (off_q + ext_len > len_w) begin
                    err_set = 1'b1;
                    nxt     = ST_DONE;
                end else begin
                    nxt = ST_EXT_CHK;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign done    = (state == ST_DONE);
    assign hdr_err = err_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == ST_IDLE); // R10
    AST_WRITE_CSUM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == LEN_W'(24) || mem_addr == LEN_W'(25))); // R1
    AST_NO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !hdr_err); // R2
    AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr < ((state == ST_IDLE) ? frame_len : len_q)); // R11
    AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we)); // R11
    AST_BYPASS_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !store_fwd) |=> (done && !hdr_err)); // R9

endmodule

// File: tb/test_iphdr_csum_ins.sv
module test_iphdr_csum_ins;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             store_fwd = 1'b1;
    logic [LEN_W-1:0] frame_len = '0;
    logic             mem_rd, mem_we, done, hdr_err;
    logic [LEN_W-1:0] mem_addr;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata = 8'h00;

    logic [7:0] mem [0:255];
    logic [7:0] fr  [0:255];

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit exp_write = 1'b0;
    logic [15:0] exp_cs = 16'h0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    iphdr_csum_ins #(.LEN_W(LEN_W)) i_iphdr_csum_ins (
        .clk(clk), .rst_n(rst_n), .start(start), .store_fwd(store_fwd),
        .frame_len(frame_len), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .hdr_err(hdr_err)
    );

    // buffer model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    // per-clock comparison of the write port against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (mem_we) begin
                checks++;
                if (!exp_write ||
                    !((mem_addr == 12'd24 && mem_wdata == exp_cs[15:8]) ||
                      (mem_addr == 12'd25 && mem_wdata == exp_cs[7:0]))) begin
                    errors++;
                    $display("FAIL %s write: addr=%0d data=%02h expected write=%0d cs=%04h",
                             cur_req, mem_addr, mem_wdata, exp_write, exp_cs);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_ext(input int c);
        return c == 0 || c == 43 || c == 44 || c == 60;
    endfunction

    // behavioural reference model
    task automatic model(input int len, input bit sf, output bit e, output bit w,
                         output logic [15:0] cs);
        int typ, ver, hl, sum, off, nh, cnt, l;
        e = 0; w = 0; cs = 16'h0;
        if (!sf || len < 14) return;
        typ = {fr[12], fr[13]};
        if (typ != 16'h0800 && typ != 16'h86DD) return;
        if (len < 15) begin e = 1; return; end
        ver = fr[14][7:4];
        hl  = fr[14][3:0] * 4;
        if (typ == 16'h0800) begin
            if (ver != 4 || hl < 20 || 14 + hl > len) begin e = 1; return; end
            sum = 0;
            for (int i = 0; i < hl; i += 2)
                if (i != 10) sum += {fr[14+i], fr[15+i]};
            while (sum > 16'hFFFF) sum = (sum & 16'hFFFF) + (sum >> 16);
            cs = ~sum[15:0];
            w = 1;
        end else begin
            if (ver != 6 || len < 54) begin e = 1; return; end
            off = 54; nh = fr[20]; cnt = 0;
            while (cnt < 4 && is_ext(nh)) begin
                if (off + 2 > len) begin e = 1; return; end
                l = (fr[off+1] + 1) * 8;
                nh = fr[off];
                if (off + l > len) begin e = 1; return; end
                off += l; cnt++;
            end
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) fr[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    task automatic set_v4(input int ver, input int ihl);
        fr[12] = 8'h08; fr[13] = 8'h00; fr[14] = 8'((ver << 4) | ihl);
        fr[24] = 8'hA5; fr[25] = 8'h5A;
    endtask

    task automatic set_v6(input int ver, input int nh);
        fr[12] = 8'h86; fr[13] = 8'hDD; fr[14] = 8'((ver << 4) | 2); fr[20] = 8'(nh);
    endtask

    task automatic run(input int len, input bit sf, input string req);
        bit e, w;
        logic [15:0] cs;
        int cyc, bad;
        model(len, sf, e, w, cs);
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = fr[i];
        exp_write = w; exp_cs = cs; cur_req = req; done_cnt = 0;
        frame_len = LEN_W'(len); store_fwd = sf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done_cnt == 0 && cyc < 500) begin @(negedge clk); cyc++; end
        check(done_cnt == 1, req, "done seen", done_cnt, 1);
        check(hdr_err == e, req, "hdr_err", int'(hdr_err), int'(e));
        bad = -1;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] x;
            x = fr[i];
            if (w && i == 24) x = cs[15:8];
            if (w && i == 25) x = cs[7:0];
            if (mem[i] !== x && bad < 0) bad = i;
        end
        check(bad < 0, req, "buffer byte index of first mismatch", bad, -1);
        @(negedge clk);
        check(done_cnt == 1 && !done, req, "done pulse count", done_cnt, 1);
        check(hdr_err == e, req, "hdr_err held", int'(hdr_err), int'(e));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !mem_we && !mem_rd && !hdr_err, "R10", "reset outputs idle",
              int'({done, mem_we, mem_rd, hdr_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        fill(5);  set_v4(4, 5);  run(60, 1, "R1");
        fill(9);  set_v4(4, 6);  run(64, 1, "R1");
        fill(3);  set_v4(4, 15); run(74, 1, "R4");
        fill(3);  set_v4(4, 15); run(73, 1, "R4");
        fill(11); set_v4(6, 5);  run(60, 1, "R2");
        fill(13); set_v4(4, 4);  run(60, 1, "R3");
        fill(17); set_v6(6, 6);  run(54, 1, "R5");
        fill(17); set_v6(4, 6);  run(60, 1, "R5");
        fill(19); set_v6(6, 6);  run(53, 1, "R6");
        fill(21); set_v6(6, 0);  fr[54] = 8'd6; fr[55] = 8'd0; run(62, 1, "R7");
        fill(21); set_v6(6, 0);  fr[54] = 8'd6; fr[55] = 8'd0; run(61, 1, "R7");
        fill(23); set_v6(6, 0);  run(55, 1, "R7");
        fill(25); set_v6(6, 60); fr[54] = 8'd17; fr[55] = 8'd1; run(69, 1, "R7");
        fill(27); set_v6(6, 60);
        fr[54] = 8'd43; fr[55] = 8'd0; fr[62] = 8'd44; fr[63] = 8'd0;
        fr[70] = 8'd0;  fr[71] = 8'd0; fr[78] = 8'd60; fr[79] = 8'd0;
        run(86, 1, "R7");
        fill(29); fr[12] = 8'h08; fr[13] = 8'h06; run(60, 1, "R8");
        fill(29); run(13, 1, "R8");
        fill(31); set_v4(4, 5); run(14, 1, "R8");
        fill(33); set_v4(4, 5); run(60, 0, "R9");
        for (int k = 0; k < 6; k++) begin
            fill(int'($urandom_range(0, 255)));
            for (int i = 14; i < 74; i++) fr[i] = 8'($urandom_range(0, 255));
            set_v4(4, 5 + k * 2);
            run(14 + (5 + k * 2) * 4 + k, 1, "R1");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule